// File: doc/BRIEF.md
# Intra-Period Fast PD Compensator

This block sits between a fast sampling ADC and the PWM counter of a digitally controlled buck converter. It takes many output-voltage samples in each switching period and, for every accepted sample, produces a signed proportional-plus-derivative correction to the switch on-time. The correction is registered and presented one clock after the sample, so the PWM comparator always sees the result of the newest sample rather than waiting for the next period.

The derivative term does not difference consecutive raw samples. Within each period, the block records the last sample that arrived strictly before the switch turned off. That sample becomes the period's valid sample. The derivative compares the incoming sample against the valid sample of the previous period. So the result computed at the last sample before turn-off is the difference between the valid samples of two consecutive periods. Results from samples taken after the turn-off pulse are still computed, but they are flagged as not valid.

Samples arrive on a valid/ready stream. The block never applies back-pressure outside reset, because a held-off sample would already be stale. The correction output carries a qualifying strobe and no ready, because the PWM counter consumes it as a level. The period-start and turn-off pulses are plain single-cycle inputs. Reset is synchronous and active low.

Top module: `fast_pd_comp`

## Requirements
- R1: While `rst_n` is low, `corr` is 0, `corr_valid` is 0 and `smp_ready` is 0, and the latest-sample, valid-sample and previous-valid registers all load `vref`. A first sample equal to the reference therefore yields a correction of 0.
- R2: In every cycle after the first rising clock edge with `rst_n` high, `smp_ready` is 1. A sample is accepted in any cycle where `smp_valid` and `smp_ready` are both high.
- R3: One cycle after an accepted sample s, `corr` equals floor((kp*(vref - s) + kd*(prev - s)) / 256). Here kp and kd are unsigned with 8 fractional bits, and prev is the previous period's valid sample.
- R4: `corr` is a signed OW-bit value (10 bits by default) that saturates at -512 and at 511 instead of wrapping.
- R5: In a cycle with no accepted sample, `corr` holds its value and `corr_valid` is 0 in the following cycle.
- R6: `corr_valid` is 1 one cycle after a sample accepted while the switch is on. The switch counts as on from reset or `period_start` until the first `switch_off` of the period. A sample accepted in the same cycle as, or after, that `switch_off` gives `corr_valid` 0.
- R7: On the first `switch_off` pulse of a period, the valid sample becomes the latest sample accepted in an earlier cycle. A sample arriving in the same cycle as the pulse is excluded.
- R8: Further `switch_off` pulses in the same period leave the valid sample unchanged.
- R9: A `period_start` pulse moves the valid sample into the previous-valid register, and this takes effect for a sample in the same cycle. The derivative therefore uses the last period's valid sample, not the preceding raw sample. A `switch_off` in the same cycle as `period_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | DW (12) | Unsigned ADC sample of the output voltage |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Block accepts samples (high outside reset) |
| period_start | input | 1 | Single-cycle pulse at the start of each switching period |
| switch_off | input | 1 | Single-cycle pulse when the main switch turns off |
| vref | input | DW (12) | Reference voltage code |
| kp | input | GW (12) | Proportional gain, unsigned, 8 fractional bits |
| kd | input | GW (12) | Derivative gain, unsigned, 8 fractional bits |
| corr | output | OW (10) | Signed, saturated on-time correction |
| corr_valid | output | 1 | Correction comes from a sample taken while the switch was on |

## Verification
The arithmetic is exercised with samples on both sides of the reference. Pure-P, pure-D and mixed gain settings separate the two terms. Single-LSB errors expose the rounding direction, and large errors drive the output into both saturation limits. A multi-period sequence uses samples that differ from the period's valid sample. This distinguishes differencing against the previous valid sample from differencing against the previous raw sample. It also pairs a sample with the turn-off pulse in the same cycle, and repeats the turn-off pulse within one period, to show which sample is latched. Reset is applied with two different reference values, showing that both history registers load the reference rather than zero.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int FPD_DW   = 12;
  localparam int FPD_GW   = 12;
  localparam int FPD_FRAC = 8;
  localparam int FPD_OW   = 10;

  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } phase_e;
endpackage

// File: rtl/fpd_track.sv
module fpd_track
  import fpd_pkg::*;
#(
  parameter int DW = FPD_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] vref,
  input  logic          acc,
  input  logic [DW-1:0] smp,
  input  logic          period_start,
  input  logic          switch_off,
  output logic [DW-1:0] prev_eff,
  output logic [DW-1:0] valid_q,
  output phase_e        phase_q,
  output logic          live
);
  logic [DW-1:0] cur_q;
  logic [DW-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= vref;
      valid_q <= vref;
      prev_q  <= vref;
      phase_q <= PH_ON;
    end else begin
      if (acc) cur_q <= smp;
      if (period_start) begin
        prev_q  <= valid_q;
        phase_q <= PH_ON;
      end else if (switch_off && phase_q == PH_ON) begin
        valid_q <= cur_q;
        phase_q <= PH_OFF;
      end
    end
  end

  // a sample in the period-start cycle already belongs to the new period
  assign prev_eff = period_start ? valid_q : prev_q;
  assign live     = acc && (period_start || (phase_q == PH_ON && !switch_off));
endmodule

// File: rtl/fpd_math.sv
module fpd_math
  import fpd_pkg::*;
#(
  parameter int DW   = FPD_DW,
  parameter int GW   = FPD_GW,
  parameter int FRAC = FPD_FRAC,
  parameter int OW   = FPD_OW
) (
  input  logic [DW-1:0]        vref,
  input  logic [DW-1:0]        smp,
  input  logic [DW-1:0]        prev,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        kd,
  output logic signed [OW-1:0] res
);
  localparam int EW = DW + 2;
  localparam int PW = EW + GW + 2;
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OW-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - 1;

  logic signed [EW-1:0] err, dif;
  logic signed [PW-1:0] err_x, dif_x, kp_x, kd_x;
  logic signed [PW-1:0] pterm, dterm, sum, shf;

  always_comb begin
    err   = $signed({2'b00, vref}) - $signed({2'b00, smp});
    dif   = $signed({2'b00, prev}) - $signed({2'b00, smp});
    err_x = $signed({{(PW-EW){err[EW-1]}}, err});
    dif_x = $signed({{(PW-EW){dif[EW-1]}}, dif});
    kp_x  = $signed({{(PW-GW){1'b0}}, kp});
    kd_x  = $signed({{(PW-GW){1'b0}}, kd});
    pterm = err_x * kp_x;
    dterm = dif_x * kd_x;
    sum   = pterm + dterm;
    shf   = sum >>> FRAC;
    if (shf > MAXV)      res = MAXV[OW-1:0];
    else if (shf < MINV) res = MINV[OW-1:0];
    else                 res = shf[OW-1:0];
  end
endmodule

// File: rtl/fast_pd_comp.sv
module fast_pd_comp
  import fpd_pkg::*;
#(
  parameter int DW   = FPD_DW,
  parameter int GW   = FPD_GW,
  parameter int FRAC = FPD_FRAC,
  parameter int OW   = FPD_OW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        smp_data,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic                 period_start,
  input  logic                 switch_off,
  input  logic [DW-1:0]        vref,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        kd,
  output logic signed [OW-1:0] corr,
  output logic                 corr_valid
);
  logic                 rdy_q;
  logic                 acc;
  logic [DW-1:0]        prev_eff;
  logic [DW-1:0]        trk_valid;
  phase_e               trk_phase;
  logic                 live;
  logic signed [OW-1:0] res;

  assign acc = smp_valid && rdy_q;

  fpd_track #(.DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .vref(vref), .acc(acc), .smp(smp_data),
    .period_start(period_start), .switch_off(switch_off),
    .prev_eff(prev_eff), .valid_q(trk_valid), .phase_q(trk_phase), .live(live)
  );

  fpd_math #(.DW(DW), .GW(GW), .FRAC(FRAC), .OW(OW)) u_math (
    .vref(vref), .smp(smp_data), .prev(prev_eff), .kp(kp), .kd(kd), .res(res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      corr       <= '0;
      corr_valid <= 1'b0;
    end else begin
      rdy_q      <= 1'b1;
      corr_valid <= live;
      if (acc) corr <= res;
    end
  end

  assign smp_ready = rdy_q;
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker
  import fpd_pkg::*;
#(
  parameter int DW = FPD_DW,
  parameter int OW = FPD_OW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic                 smp_ready,
  input logic                 period_start,
  input logic signed [OW-1:0] corr,
  input logic                 corr_valid,
  input phase_e               phase,
  input logic [DW-1:0]        valid_smp
);
  assert_reset_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (corr == '0) && !corr_valid && !smp_ready);

  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) |=> $stable(corr) && !corr_valid);

  assert_live_needs_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> $past(smp_valid && smp_ready));

  assert_latch_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF) && !period_start |=> $stable(valid_smp));
endmodule

bind fast_pd_comp fpd_checker #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .period_start(period_start), .corr(corr), .corr_valid(corr_valid),
  .phase(trk_phase), .valid_smp(trk_valid)
);

// File: tb/fast_pd_comp_test.sv
module fast_pd_comp_test;
  localparam int DW = 12, GW = 12, OW = 10, NV = 10;

  typedef struct packed {
    logic [DW-1:0]        s;
    logic [GW-1:0]        kp;
    logic [GW-1:0]        kd;
    logic signed [OW-1:0] exp;
  } vec_t;

  // vref = 2048, previous valid sample = 2048 after reset
  localparam vec_t VECS [NV] = '{
    '{12'd2048, 12'd256, 12'd0,   10'sd0},
    '{12'd2000, 12'd256, 12'd0,   10'sd48},
    '{12'd2100, 12'd256, 12'd0,  -10'sd52},
    '{12'd2000, 12'd128, 12'd128, 10'sd48},
    '{12'd2047, 12'd1,   12'd0,   10'sd0},
    '{12'd2049, 12'd1,   12'd0,  -10'sd1},
    '{12'd1000, 12'd256, 12'd0,   10'sd511},
    '{12'd3000, 12'd256, 12'd0,  -10'sd512},
    '{12'd2040, 12'd512, 12'd256, 10'sd24},
    '{12'd2060, 12'd0,   12'd384,-10'sd18}
  };

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] smp_data = '0, vref = 12'd2048;
  logic [GW-1:0] kp = '0, kd = '0;
  logic smp_valid = 0, period_start = 0, switch_off = 0;
  logic smp_ready, corr_valid;
  logic signed [OW-1:0] corr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fast_pd_comp uut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .period_start(period_start), .switch_off(switch_off),
    .vref(vref), .kp(kp), .kd(kd), .corr(corr), .corr_valid(corr_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [DW-1:0] r);
    @(negedge clk);
    rst_n = 0; vref = r;
    repeat (3) @(negedge clk);
    chk("R1 corr in reset", int'(corr), 0);
    chk("R1 corr_valid in reset", int'(corr_valid), 0);
    chk("R1 ready in reset", int'(smp_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R2 ready after reset", int'(smp_ready), 1);
  endtask

  // drive one sample (optionally with pulses), check one cycle later
  task automatic samp(input logic [DW-1:0] s, input logic off, input logic ps,
                      input string req, input int exp_c, input int exp_v);
    smp_data = s; smp_valid = 1; switch_off = off; period_start = ps;
    @(negedge clk);
    smp_valid = 0; switch_off = 0; period_start = 0;
    chk(req, int'(corr), exp_c);
    chk({req, " valid"}, int'(corr_valid), exp_v);
  endtask

  task automatic pulse(input logic off, input logic ps);
    switch_off = off; period_start = ps;
    @(negedge clk);
    switch_off = 0; period_start = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset(12'd2048);
    // R3 R4 R6: vector table, switch on throughout
    for (int i = 0; i < NV; i++) begin
      kp = VECS[i].kp; kd = VECS[i].kd;
      samp(VECS[i].s, 0, 0, "R3/R4 vector", int'(VECS[i].exp), 1);
    end

    // R9 R6 R7: derivative over valid samples of consecutive periods
    kp = 0; kd = 12'd256;
    pulse(0, 1);
    samp(12'd2010, 0, 0, "R9 D vs reset ref", 38, 1);
    samp(12'd2020, 0, 0, "R9 D second sample", 28, 1);
    pulse(1, 0);
    samp(12'd2030, 0, 0, "R6 after turn-off", 18, 0);
    pulse(0, 1);
    samp(12'd2030, 0, 0, "R9 prev valid not prev raw", -10, 1);

    // R7: sample in the turn-off cycle is excluded
    pulse(0, 1);
    samp(12'd2000, 0, 0, "R9 no turn-off keeps valid", 20, 1);
    samp(12'd2005, 1, 0, "R6 same-cycle turn-off", 15, 0);
    pulse(0, 1);
    samp(12'd2010, 0, 0, "R7 latched earlier sample", -10, 1);

    // R8: second turn-off ignored
    samp(12'd1990, 0, 0, "R8 setup", 10, 1);
    pulse(1, 0);
    samp(12'd1980, 0, 0, "R8 off sample", 20, 0);
    pulse(1, 0);
    pulse(0, 1);
    samp(12'd2000, 0, 0, "R8 second turn-off ignored", -10, 1);

    // R5: idle cycles hold the output
    smp_data = 12'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 hold corr", int'(corr), -10);
      chk("R5 corr_valid low", int'(corr_valid), 0);
    end

    // R1: reset loads the reference into history
    do_reset(12'd1000);
    kp = 0; kd = 12'd256;
    samp(12'd1000, 0, 0, "R1 first D zero", 0, 1);
    samp(12'd990, 0, 0, "R1 prev equals ref", 10, 1);
    kp = 12'd256;
    samp(12'd1000, 0, 0, "R3 P and D", 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule